// File: doc/BRIEF.md
# Merging Write Buffer for a Write-Through Cache

This block sits between a write-through data cache and the next memory level. Every processor store that the cache accepts is also handed to this buffer, which keeps up to four pending block-sized entries. Each entry holds one block address and four 32-bit word lanes, and each lane has its own valid flag. A store whose block already has an open entry is folded into that entry, so sequential stores to one block cost a single memory transaction.

Entries leave the buffer oldest first. The oldest entry is launched towards memory when memory reports it can take a request and no read miss is being looked up. From the launch onward that entry is frozen: later stores to the same block open a fresh entry behind it. The launched entry is offered with a per-lane write mask until memory acknowledges it.

A read-miss lookup port checks a missed word address against every buffered word in the same cycle and returns the most recently written copy. A read miss can therefore be served from the buffer, or sent to memory ahead of the queued writes without returning stale data. While a lookup is requested, the buffer does not launch a new drain.

Top module: `wmb_merge_buf`

## Requirements
- R1: After reset the buffer is empty: `st_ready` is 1, `mem_req` is 0 and `rd_hit` is 0 for any address.
- R2: Byte addresses split as block = addr[31:4] and word lane = addr[3:2]. A store to a block with no open entry takes the next free entry, and only that lane is valid.
- R3: A store to a block that has an open (not launched) entry merges into that entry and does not take a new one. Stores to 0x100, 0x104, 0x108 and 0x10C fill one entry with mask 4'b1111.
- R4: A store to a lane that is already valid overwrites it, and the later data is the data drained.
- R5: When all four entries are in use, `st_ready` is 0 for a store that cannot merge, and it stays 1 for a store that merges into an open entry.
- R6: Entries drain in allocation order. `mem_mask` bit i is lane i's valid flag. Lane i occupies `mem_data[32*i +: 32]`, and invalid lanes read as zero.
- R7: Once an entry is launched (`mem_req` high), it accepts no merges. A store to its block allocates a new entry, which drains after it.
- R8: With `rd_req` high, `rd_hit` is 1 in the same cycle if the word at `rd_addr` is valid in any buffered entry, including a launched one. `rd_data` then returns the youngest such copy. A different lane of the same block is a miss.
- R9: While `rd_req` is high, no new drain is launched, even with `mem_ready` high and entries pending.
- R10: `mem_req` stays high, with block, mask and data unchanged, until `mem_ack` is seen. The entry is freed on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request from the cache |
| st_addr | input | 32 | Store byte address (word aligned) |
| st_data | input | 32 | Store data |
| st_ready | output | 1 | Store can be taken this cycle; low stalls the processor |
| rd_req | input | 1 | Read-miss lookup request |
| rd_addr | input | 32 | Read-miss byte address |
| rd_hit | output | 1 | Missed word is held in the buffer |
| rd_data | output | 32 | Youngest buffered copy of the missed word |
| mem_ready | input | 1 | Memory can start a write |
| mem_req | output | 1 | A launched entry is being offered to memory |
| mem_blk | output | 28 | Block address of the offered entry |
| mem_mask | output | 4 | Per-lane write mask of the offered entry |
| mem_data | output | 128 | Lane data of the offered entry |
| mem_ack | input | 1 | Memory has taken the offered entry |

## Verification
If the buffer wrongly allocates an entry for a store that should merge, `st_ready` drops one store too early when four distinct blocks are then written. It also shows up as an extra memory write in the drain sequence. If a lane valid bit or its data is lost, it shows at once as a wrong `rd_hit` or `rd_data`, and later as a wrong `mem_mask` or lane value when the entry drains. Ordering or launch-gating faults show within a cycle of the lookup or acknowledge as a wrong `mem_req` level, or as a wrong block address in the drain sequence.

// File: rtl/wmb_pkg.sv
package wmb_pkg;
    parameter int WB_DEPTH = 4;
    parameter int WB_WORDS = 4;
    parameter int WB_DW    = 32;
    parameter int WB_AW    = 32;

    localparam int WB_PTR_W = $clog2(WB_DEPTH);
    localparam int WB_OFF_W = $clog2(WB_WORDS);
    localparam int WB_BLK_W = WB_AW - WB_OFF_W - 2;
    localparam int WB_CNT_W = $clog2(WB_DEPTH + 1);

    typedef struct packed {
        logic                            used;
        logic [WB_BLK_W-1:0]             blk;
        logic [WB_WORDS-1:0]             vld;
        logic [WB_WORDS-1:0][WB_DW-1:0]  dat;
    } wb_ent_t;

    typedef struct packed {
        wb_ent_t [WB_DEPTH-1:0]  ent;
        logic [WB_PTR_W-1:0]     head;
        logic [WB_PTR_W-1:0]     tail;
        logic [WB_CNT_W-1:0]     cnt;
        logic                    busy;
    } wb_state_t;

    function automatic logic [WB_PTR_W-1:0] ptr_inc(input logic [WB_PTR_W-1:0] p);
        return (int'(p) == WB_DEPTH - 1) ? '0 : p + 1'b1;
    endfunction
endpackage

// File: rtl/wmb_match.sv
// Finds the open entry (used, not launched) holding a given block.
module wmb_match
    import wmb_pkg::*;
(
    input  wb_ent_t [WB_DEPTH-1:0] ents,
    input  logic [WB_PTR_W-1:0]    head,
    input  logic                   busy,
    input  logic [WB_BLK_W-1:0]    blk,
    output logic                   hit,
    output logic [WB_PTR_W-1:0]    idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < WB_DEPTH; i++) begin
            if (ents[i].used && ents[i].blk == blk &&
                !(busy && WB_PTR_W'(i) == head)) begin
                hit = 1'b1;
                idx = WB_PTR_W'(i);
            end
        end
    end
endmodule

// File: rtl/wmb_lookup.sv
// Read-miss probe: scans oldest to youngest so the youngest copy wins.
module wmb_lookup
    import wmb_pkg::*;
(
    input  wb_ent_t [WB_DEPTH-1:0] ents,
    input  logic [WB_PTR_W-1:0]    head,
    input  logic [WB_BLK_W-1:0]    blk,
    input  logic [WB_OFF_W-1:0]    off,
    output logic                   hit,
    output logic [WB_DW-1:0]       data
);
    always_comb begin
        hit  = 1'b0;
        data = '0;
        for (int a = 0; a < WB_DEPTH; a++) begin
            int k;
            k = (int'(head) + a) % WB_DEPTH;
            if (ents[k].used && ents[k].blk == blk && ents[k].vld[off]) begin
                hit  = 1'b1;
                data = ents[k].dat[off];
            end
        end
    end
endmodule

// File: rtl/wmb_merge_buf.sv
module wmb_merge_buf
    import wmb_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      st_valid,
    input  logic [WB_AW-1:0]          st_addr,
    input  logic [WB_DW-1:0]          st_data,
    output logic                      st_ready,
    input  logic                      rd_req,
    input  logic [WB_AW-1:0]          rd_addr,
    output logic                      rd_hit,
    output logic [WB_DW-1:0]          rd_data,
    input  logic                      mem_ready,
    output logic                      mem_req,
    output logic [WB_BLK_W-1:0]       mem_blk,
    output logic [WB_WORDS-1:0]       mem_mask,
    output logic [WB_WORDS*WB_DW-1:0] mem_data,
    input  logic                      mem_ack
);
    wb_state_t s_d, s_q;

    logic [WB_BLK_W-1:0] st_blk, rd_blk;
    logic [WB_OFF_W-1:0] st_off, rd_off;
    logic                m_hit, lk_hit, st_fire, pop, launch, alloc;
    logic [WB_PTR_W-1:0] m_idx;
    logic [WB_DW-1:0]    lk_data;

    assign st_blk = st_addr[WB_AW-1 -: WB_BLK_W];
    assign st_off = st_addr[2 +: WB_OFF_W];
    assign rd_blk = rd_addr[WB_AW-1 -: WB_BLK_W];
    assign rd_off = rd_addr[2 +: WB_OFF_W];

    wmb_match u_match (
        .ents (s_q.ent),
        .head (s_q.head),
        .busy (s_q.busy),
        .blk  (st_blk),
        .hit  (m_hit),
        .idx  (m_idx)
    );

    wmb_lookup u_lookup (
        .ents (s_q.ent),
        .head (s_q.head),
        .blk  (rd_blk),
        .off  (rd_off),
        .hit  (lk_hit),
        .data (lk_data)
    );

    always_comb begin
        s_d      = s_q;
        st_ready = m_hit || (s_q.cnt < WB_CNT_W'(WB_DEPTH));
        st_fire  = st_valid && st_ready;
        alloc    = st_fire && !m_hit;
        pop      = s_q.busy && mem_ack;
        launch   = !s_q.busy && (s_q.cnt != '0) && mem_ready && !rd_req;

        if (pop) begin
            s_d.ent[s_q.head] = '0;
            s_d.head          = ptr_inc(s_q.head);
            s_d.busy          = 1'b0;
        end
        if (launch) begin
            s_d.busy = 1'b1;
        end
        if (st_fire) begin
            if (m_hit) begin
                s_d.ent[m_idx].vld[st_off] = 1'b1;
                s_d.ent[m_idx].dat[st_off] = st_data;
            end else begin
                s_d.ent[s_q.tail]             = '0;
                s_d.ent[s_q.tail].used        = 1'b1;
                s_d.ent[s_q.tail].blk         = st_blk;
                s_d.ent[s_q.tail].vld[st_off] = 1'b1;
                s_d.ent[s_q.tail].dat[st_off] = st_data;
                s_d.tail                      = ptr_inc(s_q.tail);
            end
        end
        s_d.cnt = s_q.cnt + WB_CNT_W'(alloc) - WB_CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_hit   = rd_req && lk_hit;
    assign rd_data  = rd_hit ? lk_data : '0;
    assign mem_req  = s_q.busy;
    assign mem_blk  = s_q.ent[s_q.head].blk;
    assign mem_mask = s_q.ent[s_q.head].vld;
    assign mem_data = s_q.ent[s_q.head].dat;

    // R10: offered entry is held unchanged until taken
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_blk) && $stable(mem_mask) && $stable(mem_data));

    // R9: a pending lookup blocks a new launch
    assert_read_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_req && rd_req |=> !mem_req);

    // R5: occupancy never exceeds the entry count
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= WB_CNT_W'(WB_DEPTH));

    // R6: an offered entry always carries at least one lane
    assert_mask_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_mask != '0);

    // R3: a merging store leaves occupancy unchanged
    assert_merge_no_alloc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && st_ready && m_hit && !(mem_req && mem_ack) |=> s_q.cnt == $past(s_q.cnt));

    // R7: the launched entry is never the merge target
    assert_launched_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && m_hit |-> m_idx != s_q.head);
endmodule

// File: tb/wmb_merge_buf_tb.sv
module wmb_merge_buf_tb;
    logic         clk = 0;
    logic         rst_n = 0;
    logic         st_valid = 0;
    logic [31:0]  st_addr = 0;
    logic [31:0]  st_data = 0;
    logic         st_ready;
    logic         rd_req = 0;
    logic [31:0]  rd_addr = 0;
    logic         rd_hit;
    logic [31:0]  rd_data;
    logic         mem_ready = 0;
    logic         mem_req;
    logic [27:0]  mem_blk;
    logic [3:0]   mem_mask;
    logic [127:0] mem_data;
    logic         mem_ack = 0;

    int checks = 0;
    int failures = 0;
    bit ack_en = 0;

    typedef struct packed {
        logic [27:0]  blk;
        logic [3:0]   mask;
        logic [127:0] data;
    } drain_t;
    drain_t exp_q[$];

    always #5 clk = ~clk;

    wmb_merge_buf u_dut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_ready(st_ready),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_hit(rd_hit), .rd_data(rd_data),
        .mem_ready(mem_ready), .mem_req(mem_req), .mem_blk(mem_blk),
        .mem_mask(mem_mask), .mem_data(mem_data), .mem_ack(mem_ack)
    );

    task automatic chk(input string req, input logic [159:0] act, input logic [159:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_drain(input logic [31:0] addr, input logic [3:0] mask, input logic [127:0] data);
        drain_t e;
        e.blk = addr[31:4];
        e.mask = mask;
        e.data = data;
        exp_q.push_back(e);
    endtask

    // Monitor: acknowledges offered entries and compares with the scoreboard (R6, R7)
    always @(negedge clk) begin
        if (mem_req && ack_en && !mem_ack) begin
            if (exp_q.size() == 0) begin
                chk("R6 unexpected drain", {mem_blk, mem_mask, mem_data}, '0);
            end else begin
                drain_t e;
                e = exp_q.pop_front();
                chk("R6 drain order/mask/data", {mem_blk, mem_mask, mem_data}, {e.blk, e.mask, e.data});
            end
            mem_ack = 1;
        end else begin
            mem_ack = 0;
        end
    end

    task automatic store(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        st_valid = 1; st_addr = a; st_data = d;
        #1;
        while (!st_ready) begin
            @(negedge clk); #1;
        end
        @(posedge clk); #1;
        st_valid = 0;
    endtask

    task automatic lookup(input string req, input logic [31:0] a, input logic h, input logic [31:0] d);
        @(negedge clk);
        rd_req = 1; rd_addr = a;
        #1;
        chk(req, {rd_hit, rd_data}, {h, d});
    endtask

    task automatic wait_drained();
        @(negedge clk);
        while (exp_q.size() != 0 || mem_req) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [27:0]  h_blk;
        logic [3:0]   h_mask;
        logic [127:0] h_data;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        rd_req = 1; rd_addr = 32'h100;
        #1;
        chk("R1 st_ready", st_ready, 1);
        chk("R1 mem_req", mem_req, 0);
        chk("R1 rd_hit", rd_hit, 0);
        rd_req = 0;

        // R3: four sequential words merge into one entry
        store(32'h100, 32'h11); store(32'h104, 32'h22);
        store(32'h108, 32'h33); store(32'h10C, 32'h44);
        lookup("R8 hit merged word", 32'h108, 1, 32'h33);
        lookup("R8 miss other block", 32'h110, 0, 0);
        @(negedge clk); rd_req = 0;
        // R2: three more blocks each take one entry
        store(32'h200, 32'h55); store(32'h304, 32'h66); store(32'h408, 32'h77);
        // R5: full, non-merging store stalls (also shows R3 used one entry)
        @(negedge clk);
        st_valid = 1; st_addr = 32'h500; st_data = 32'hEE;
        #1;
        chk("R5 full stall", st_ready, 0);
        st_addr = 32'h104; st_data = 32'h99;
        #1;
        chk("R5 merge while full", st_ready, 1);
        @(posedge clk); #1; st_valid = 0;
        // R4: overwrite of lane 1 drains the newer value
        expect_drain(32'h100, 4'b1111, {32'h44, 32'h33, 32'h99, 32'h11});
        expect_drain(32'h200, 4'b0001, {96'h0, 32'h55});
        expect_drain(32'h304, 4'b0010, {64'h0, 32'h66, 32'h0});
        expect_drain(32'h408, 4'b0100, {32'h0, 32'h77, 64'h0});
        mem_ready = 1; ack_en = 1;
        wait_drained();
        chk("R6 idle after drain", mem_req, 0);
        chk("R6 scoreboard empty", exp_q.size(), 0);

        // R9: pending lookup holds off launch
        ack_en = 0;
        @(negedge clk); rd_req = 1; rd_addr = 32'h900;
        store(32'h608, 32'hA1);
        repeat (3) begin
            @(negedge clk);
            chk("R9 no launch during lookup", mem_req, 0);
        end
        rd_req = 0;
        @(negedge clk);
        chk("R9 launch after lookup", mem_req, 1);
        // R10: payload held until acknowledged
        h_blk = mem_blk; h_mask = mem_mask; h_data = mem_data;
        chk("R2 single-lane mask", h_mask, 4'b0100);
        repeat (3) @(negedge clk);
        chk("R10 held", {mem_req, mem_blk, mem_mask, mem_data}, {1'b1, h_blk, h_mask, h_data});

        // R7: launched entry is closed; same block gets a new entry
        store(32'h608, 32'hB2);
        store(32'h600, 32'hB0);
        lookup("R8 youngest copy", 32'h608, 1, 32'hB2);
        lookup("R8 other lane same block", 32'h604, 0, 0);
        @(negedge clk); rd_req = 0;
        chk("R10 still held", {mem_req, mem_data}, {1'b1, h_data});
        expect_drain(32'h600, 4'b0100, {32'h0, 32'hA1, 64'h0});
        expect_drain(32'h600, 4'b0101, {32'h0, 32'hB2, 32'h0, 32'hB0});
        ack_en = 1;
        wait_drained();
        chk("R7 both entries drained", exp_q.size(), 0);
        chk("R1 ready when empty", st_ready, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule